// File: doc/BRIEF.md
# Subranging Converter Digital Error Corrector

This block is the digital back end of a two-step subranging analog-to-digital converter. The coarse and fine flash encoders each deliver an 8-bit code with a strobe. The block holds each code in its own latch and moves the pair into a joint staging register once the fine strobe has passed. It then adds the two codes with a two-bit overlap into one 14-bit sample. The fine code carries a fixed bias that centres its range on the coarse step, so the sum can fall below zero or rise above full scale. Either excursion clamps to the nearest end of the scale and never wraps.

The corrected sample is coded as two's complement, or as its bitwise inverse when the format input is high. Results are read out in one of two ways. In command-paced mode, every convert command shifts a three-deep result chain, and the bus shows the sample from two or three commands earlier. In strobe-paced mode, each finished conversion is shown on its own and flagged by a one-cycle ready pulse, so a single conversion gives valid data. An active-high release input puts the output bus in high impedance.

Top module: `subrange_corrector`

## Requirements
- R1: The coarse code is captured only on a cycle with `coarse_stb` high, and the fine code only on a cycle with `fine_stb` high. Changes on either code input at other times have no effect on the result.
- R2: The staging register takes both latched codes on the clock edge after the fine strobe is captured. A coarse strobe captured on that same edge does not change the sample being formed.
- R3: The offset sum is coarse·64 + fine − 96, with the coarse code in bits 13:6 and the fine code in bits 7:0 of the adder. The two's complement result is that sum with bit 13 inverted, so zero is 14'h0000, +FS is 14'h1FFF and −FS is 14'h2000.
- R4: An offset sum above 16383 gives the +FS code (offset 16383) and never wraps.
- R5: An offset sum below 0 gives the −FS code (offset 0) and never wraps.
- R6: With `invert_fmt` high when the staging register is corrected, the output word is the bitwise inverse of the R3 code.
- R7: With `cmd_read` high and `lat_sel` low, the bus shows the result of conversion N−2 from the edge that captures convert command N until the next command.
- R8: With `cmd_read` high and `lat_sel` high, the bus shows the result of conversion N−3 in the same window.
- R9: With `cmd_read` low, the corrected word appears on the bus 3 clock edges after the fine strobe edge. `word_ready` is high for exactly the following cycle, and `lat_sel` has no effect.
- R10: While `out_hiz` is high the block does not drive `data_bus`. When it goes low again, the held word returns unchanged.
- R11: After reset, `data_bus` is all zeros and `word_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Convert command, one-cycle pulse |
| coarse_stb | input | 1 | Coarse code capture strobe |
| coarse_code | input | 8 | Coarse flash encoder code |
| fine_stb | input | 1 | Fine code capture strobe |
| fine_code | input | 8 | Fine flash encoder code, biased by 96 |
| cmd_read | input | 1 | 1: command-paced read-out, 0: strobe-paced read-out |
| lat_sel | input | 1 | Command-paced latency: 0 gives two commands, 1 gives three |
| invert_fmt | input | 1 | 1: inverted two's complement coding |
| out_hiz | input | 1 | 1: release the output bus |
| data_bus | output | 14 | Corrected sample, tri-stateable |
| word_ready | output | 1 | One-cycle pulse after a new word is shown |

## Verification
The bench sweeps every coarse code against fine codes at the bottom, the bias point and the top of their range, in both codings. This reaches both clamp edges. An adder that wrapped would show −FS or a small value where +FS belongs, and a missing bias would shift every code by 96. Garbage is placed on the code inputs between strobes, and a stray coarse strobe arrives right after the fine strobe. A design that latched out of turn, or staged one edge late, would mix two conversions. Two command-paced runs track a history of samples from reset, so an off-by-one chain tap shows as a stale or early word. During the release window the bench drives two complementary patterns onto the bus and reads them back, so a bus that kept driving would corrupt them.

// File: rtl/sr_pkg.sv
package sr_pkg;
   typedef enum logic [1:0] {
      SEL_LAT2 = 2'd0,
      SEL_LAT3 = 2'd1,
      SEL_DV   = 2'd2
   } rd_sel_e;
endpackage

// File: rtl/sr_code_latch.sv
module sr_code_latch #(
   parameter int CW = 8,
   parameter int FW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             coarse_stb,
   input  logic [CW-1:0]    coarse_code,
   input  logic             fine_stb,
   input  logic [FW-1:0]    fine_code,
   output logic [CW+FW-1:0] stg_word,
   output logic             stg_vld
);
   localparam int SW = CW + FW;

   logic [CW-1:0] coarse_q;
   logic [FW-1:0] fine_q;
   logic          xfer_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_q <= '0;
      end else if (coarse_stb) begin
         coarse_q <= coarse_code;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fine_q <= '0;
         xfer_q <= 1'b0;
      end else begin
         xfer_q <= fine_stb;
         if (fine_stb) begin
            fine_q <= fine_code;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_word <= '0;
         stg_vld  <= 1'b0;
      end else begin
         stg_vld <= xfer_q;
         if (xfer_q) begin
            stg_word <= SW'({coarse_q, fine_q});
         end
      end
   end

   AST_STAGE_AFTER_FINE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stg_vld) |-> $past(xfer_q)) // R2
      else $error("staging without a preceding fine strobe");
endmodule

// File: rtl/sr_overlap_adder.sv
module sr_overlap_adder #(
   parameter int CW   = 8,
   parameter int FW   = 8,
   parameter int OW   = 14,
   parameter int BIAS = 96
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW+FW-1:0] stg_word,
   input  logic             stg_vld,
   input  logic             invert_fmt,
   output logic [OW-1:0]    corr_word,
   output logic             corr_vld
);
   localparam int SHIFT = OW - CW;
   localparam int SW    = OW + 2;
   localparam int MAXV  = (2 ** OW) - 1;
   localparam logic [OW-1:0] MSB_MASK = OW'(1) << (OW - 1);

   logic [CW-1:0]        c_part;
   logic [FW-1:0]        f_part;
   logic signed [SW-1:0] sum_s;
   logic [OW-1:0]        off_sat;
   logic [OW-1:0]        tc_word;
   logic [OW-1:0]        fmt_word;
   logic                 inv_q;

   assign c_part = stg_word[CW+FW-1:FW];
   assign f_part = stg_word[FW-1:0];

   always_comb begin
      sum_s = signed'(SW'({c_part, {SHIFT{1'b0}}}))
            + signed'(SW'(f_part))
            - signed'(SW'(BIAS));
      if (sum_s < 0) begin
         off_sat = '0;
      end else if (sum_s > signed'(SW'(MAXV))) begin
         off_sat = '1;
      end else begin
         off_sat = sum_s[OW-1:0];
      end
      tc_word  = off_sat ^ MSB_MASK;
      fmt_word = invert_fmt ? ~tc_word : tc_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr_word <= '0;
         inv_q     <= 1'b0;
         corr_vld  <= 1'b0;
      end else begin
         corr_vld <= stg_vld;
         if (stg_vld) begin
            corr_word <= fmt_word;
            inv_q     <= invert_fmt;
         end
      end
   end

   logic [OW-1:0] chk_off;
   assign chk_off = corr_word ^ {OW{inv_q}} ^ MSB_MASK;

   AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_vld && (&c_part)) |=> chk_off[OW-1]) // R4
      else $error("top coarse code wrapped");

   AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_vld && (c_part == '0)) |=> !chk_off[OW-1]) // R5
      else $error("bottom coarse code wrapped");
endmodule

// File: rtl/sr_readout.sv
module sr_readout
   import sr_pkg::*;
#(
   parameter int OW    = 14,
   parameter int DEPTH = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          conv_start,
   input  logic [OW-1:0] corr_word,
   input  logic          corr_vld,
   input  logic          cmd_read,
   input  logic          lat_sel,
   output logic [OW-1:0] out_word,
   output logic          out_dv
);
   logic [OW-1:0] chain_q [DEPTH];
   logic [OW-1:0] dvw_q;
   logic          ld_q;
   logic          dv_q;
   logic          cmd_dv_q;
   rd_sel_e       sel;

   for (genvar i = 0; i < DEPTH; i++) begin : g_chain
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          chain_q[0] <= '0;
            else if (conv_start) chain_q[0] <= corr_word;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          chain_q[i] <= '0;
            else if (conv_start) chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dvw_q    <= '0;
         ld_q     <= 1'b0;
         dv_q     <= 1'b0;
         cmd_dv_q <= 1'b0;
      end else begin
         ld_q     <= corr_vld;
         dv_q     <= ld_q;
         cmd_dv_q <= conv_start;
         if (corr_vld) begin
            dvw_q <= corr_word;
         end
      end
   end

   always_comb begin
      if (!cmd_read)    sel = SEL_DV;
      else if (lat_sel) sel = SEL_LAT3;
      else              sel = SEL_LAT2;
      case (sel)
         SEL_LAT2: out_word = chain_q[1];
         SEL_LAT3: out_word = chain_q[2];
         default:  out_word = dvw_q;
      endcase
      out_dv = cmd_read ? cmd_dv_q : dv_q;
   end

   AST_CHAIN_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> (chain_q[0] == $past(corr_word))) // R7
      else $error("chain head missed the latest result");

   AST_CHAIN_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> (chain_q[2] == $past(chain_q[1]))) // R8
      else $error("chain tail did not advance");

   AST_DV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_q |-> (dvw_q == $past(corr_word))) // R9
      else $error("strobe-paced word differs from the corrected result");
endmodule

// File: rtl/subrange_corrector.sv
module subrange_corrector #(
   parameter int COARSE_W = 8,
   parameter int FINE_W   = 8,
   parameter int OUT_W    = 14,
   parameter int FINE_BIAS = 96,
   parameter int MAX_LAT  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_start,
   input  logic             coarse_stb,
   input  logic [COARSE_W-1:0] coarse_code,
   input  logic             fine_stb,
   input  logic [FINE_W-1:0] fine_code,
   input  logic             cmd_read,
   input  logic             lat_sel,
   input  logic             invert_fmt,
   input  logic             out_hiz,
   output logic [OUT_W-1:0] data_bus,
   output logic             word_ready
);
   localparam int OVERLAP = COARSE_W + FINE_W - OUT_W;

   if (OUT_W <= COARSE_W) begin : g_bad_out
      $error("output must be wider than the coarse code");
   end
   if (OVERLAP < 1) begin : g_bad_overlap
      $error("coarse and fine codes must overlap");
   end
   if (MAX_LAT < 3) begin : g_bad_lat
      $error("result chain needs at least three stages");
   end

   logic [COARSE_W+FINE_W-1:0] stg_word;
   logic                       stg_vld;
   logic [OUT_W-1:0]           corr_word;
   logic                       corr_vld;
   logic [OUT_W-1:0]           out_word;

   sr_code_latch #(.CW(COARSE_W), .FW(FINE_W)) u_latch (
      .clk(clk), .rst_n(rst_n),
      .coarse_stb(coarse_stb), .coarse_code(coarse_code),
      .fine_stb(fine_stb), .fine_code(fine_code),
      .stg_word(stg_word), .stg_vld(stg_vld)
   );

   sr_overlap_adder #(.CW(COARSE_W), .FW(FINE_W), .OW(OUT_W), .BIAS(FINE_BIAS)) u_adder (
      .clk(clk), .rst_n(rst_n),
      .stg_word(stg_word), .stg_vld(stg_vld), .invert_fmt(invert_fmt),
      .corr_word(corr_word), .corr_vld(corr_vld)
   );

   sr_readout #(.OW(OUT_W), .DEPTH(MAX_LAT)) u_readout (
      .clk(clk), .rst_n(rst_n),
      .conv_start(conv_start), .corr_word(corr_word), .corr_vld(corr_vld),
      .cmd_read(cmd_read), .lat_sel(lat_sel),
      .out_word(out_word), .out_dv(word_ready)
   );

   assign data_bus = out_hiz ? {OUT_W{1'bz}} : out_word;
endmodule

// File: tb/test_subrange_corrector.sv
module test_subrange_corrector;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_start = 0, coarse_stb = 0, fine_stb = 0;
   logic [7:0] coarse_code = 0, fine_code = 0;
   logic cmd_read = 0, lat_sel = 1, invert_fmt = 0, out_hiz = 0;
   wire  [13:0] data_bus;
   logic word_ready;
   logic tb_drv = 0;
   logic [13:0] tb_pat = 0;
   logic [13:0] cmd_sample;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   assign data_bus = tb_drv ? tb_pat : 14'bz;

   subrange_corrector i_subrange_corrector (
      .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
      .coarse_stb(coarse_stb), .coarse_code(coarse_code),
      .fine_stb(fine_stb), .fine_code(fine_code),
      .cmd_read(cmd_read), .lat_sel(lat_sel), .invert_fmt(invert_fmt),
      .out_hiz(out_hiz), .data_bus(data_bus), .word_ready(word_ready)
   );

   function automatic logic [13:0] exp_word(int c, int f, bit inv);
      int s;
      logic [13:0] w;
      s = c * 64 + f - 96;
      if (s < 0) s = 0;
      if (s > 16383) s = 16383;
      w = 14'(s) ^ 14'h2000;
      return inv ? ~w : w;
   endfunction

   task automatic check(string req, logic [13:0] act, logic [13:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   // One conversion. In strobe-paced mode the word and ready pulse are checked.
   task automatic convert(int c, int f, bit late, bit dv_chk, string req);
      conv_start = 1;
      @(negedge clk);
      conv_start = 0;
      cmd_sample = data_bus;
      coarse_code = 8'(c); coarse_stb = 1;
      @(negedge clk);
      coarse_stb = 0; coarse_code = 8'(c ^ 8'h5A);
      fine_code = 8'(f); fine_stb = 1;
      @(negedge clk);
      fine_stb = 0; fine_code = 8'(f ^ 8'hC3);  // R1: garbage between strobes
      if (late) begin coarse_stb = 1; coarse_code = 8'(~c); end
      @(negedge clk);
      coarse_stb = 0;
      repeat (3) @(negedge clk);
      if (dv_chk) begin
         checks++;
         if (word_ready !== 1'b1) begin
            errors++;
            $display("FAIL R9: word_ready %b expected 1", word_ready);
         end
         check(req, data_bus, exp_word(c, f, invert_fmt));
      end
      @(negedge clk);
      if (dv_chk) begin
         checks++;
         if (word_ready !== 1'b0) begin
            errors++;
            $display("FAIL R9: word_ready %b expected 0 after pulse", word_ready);
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [13:0] hist [16];
      int fv [3] = '{0, 96, 255};
      do_reset();
      // R11: reset state
      check("R11", data_bus, 14'h0000);
      checks++;
      if (word_ready !== 1'b0) begin
         errors++;
         $display("FAIL R11: word_ready %b expected 0", word_ready);
      end

      // R3 R4 R5 R6 R9: strobe-paced sweep over all coarse codes
      cmd_read = 0;
      for (int c = 0; c < 256; c++) begin
         for (int k = 0; k < 3; k++) begin
            invert_fmt = ((c + k) % 2) == 1;
            lat_sel = (c % 3) == 0;  // R9: ignored in this mode
            convert(c, fv[k], 1'b0, 1'b1,
                    (c == 255 && k == 2) ? "R4" : (c == 0 && k == 0) ? "R5" :
                    invert_fmt ? "R6" : "R3");
         end
      end
      invert_fmt = 0;
      convert(255, 255, 1'b0, 1'b1, "R4");
      convert(0, 0, 1'b0, 1'b1, "R5");
      convert(128, 96, 1'b0, 1'b1, "R3");
      // R2: coarse strobe on the staging edge must not leak in
      convert(77, 10, 1'b1, 1'b1, "R2");
      convert(200, 250, 1'b1, 1'b1, "R2");

      // R10: released bus, then held word returns
      out_hiz = 1;
      @(negedge clk);
      tb_drv = 1; tb_pat = 14'h1555;
      @(negedge clk);
      check("R10", data_bus, 14'h1555);
      tb_pat = 14'h2AAA;
      @(negedge clk);
      check("R10", data_bus, 14'h2AAA);
      tb_drv = 0; out_hiz = 0;
      @(negedge clk);
      check("R10", data_bus, exp_word(200, 250, 0));

      // R7: command-paced, two commands latency
      lat_sel = 0; cmd_read = 1;
      do_reset();
      for (int n = 0; n < 10; n++) begin
         hist[n] = exp_word(n * 23 + 5, (n * 41) % 256, 0);
         convert(n * 23 + 5, (n * 41) % 256, 1'b0, 1'b0, "R7");
         check("R7", cmd_sample, (n >= 2) ? hist[n-2] : 14'h0000);
      end

      // R8: command-paced, three commands latency
      lat_sel = 1; invert_fmt = 1;
      do_reset();
      for (int n = 0; n < 10; n++) begin
         hist[n] = exp_word(250 - n * 19, (n * 67) % 256, 1);
         convert(250 - n * 19, (n * 67) % 256, 1'b0, 1'b0, "R8");
         check("R8", cmd_sample, (n >= 3) ? hist[n-3] : 14'h0000);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule